// File: doc/BRIEF.md
# Delta-Sigma Bitstream Input Channel

This block is the receiving end of one delta-sigma modulator link. It watches a data pin, a second data pin borrowed from a neighbouring channel, an external bit clock and an internally generated bit clock. From these it delivers a one-bit sample and a single-cycle strobe to the decimation filter that follows. All pins are brought into the system clock domain through two-flop synchronizers, and every decision is made on edges seen after that crossing.

A 2-bit interface code picks one of two decoding styles. In the clocked style, data is captured on either the rising or the falling edge of a chosen bit clock. In the self-clocked style, the line carries Manchester code. The decoder finds the mid-bit transitions by counting system clocks against a programmed bit period. A 2-bit source code picks the bit clock for the clocked style: the external pin, the internal clock, or the internal clock halved, where the halved clock changes state on either the falling or the rising edges of the internal clock. When the enable input is low the channel emits nothing and its decoder state is cleared.

Top module: `sd_rx_channel`

## Requirements
- R1: After a synchronous active-low reset, `smp_valid` and `smp_bit` are 0.
- R2: Interface code 0 captures the selected data pin on each rising edge of the selected bit clock and emits one strobe per captured bit. The strobe appears three system clocks after the first system clock edge that sees the new clock level.
- R3: Interface code 1 captures on each falling edge of the selected bit clock, with the same latency as R2.
- R4: Interface code 2 decodes Manchester code. A rising mid-bit transition gives bit 0 and a falling one gives bit 1, with one strobe per decoded bit.
- R5: Interface code 3 decodes Manchester code with the opposite polarity: a rising mid-bit transition gives bit 1 and a falling one gives bit 0.
- R6: Source code 0 selects the external clock pin and code 1 the internal clock pin. Code 2 selects a halved clock that starts low at enable and toggles on every internal falling edge. Code 3 selects a halved clock that toggles on every internal rising edge. With codes 2 and 3, the rising edge of the halved clock is its first toggle after enable.
- R7: The alternate-select input set to 0 takes data from `sd_data`; set to 1, it takes data from `sd_data_alt`. The unselected pin has no effect.
- R8: While `cfg_enable` is 0 no strobe is produced, whatever happens on the pins. A capture whose output register update falls in a cycle where enable is 0 is dropped.
- R9: Clearing `cfg_enable` flushes the Manchester decoder. After enable returns, the first line transition is taken as a mid-bit transition, however soon it comes.
- R10: In Manchester modes, a transition is decoded only once at least 3/4 of `cfg_bit_cycles` system clocks have passed since the last decoded transition. An earlier transition, such as a bit boundary, is ignored. An early transition does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_type | input | 2 | Interface code (0 rise capture, 1 fall capture, 2 and 3 Manchester) |
| cfg_clk_src | input | 2 | Bit clock source code |
| cfg_alt_sel | input | 1 | 1 selects the alternate data pin |
| cfg_bit_cycles | input | CNT_W | Manchester bit period in system clocks |
| sd_data | input | 1 | Own data pin (asynchronous) |
| sd_data_alt | input | 1 | Neighbouring data pin (asynchronous) |
| sd_clk_ext | input | 1 | External bit clock pin (asynchronous) |
| sd_clk_int | input | 1 | Internal bit clock (asynchronous to clk) |
| smp_bit | output | 1 | Last captured or decoded bit |
| smp_valid | output | 1 | One-cycle strobe for a new bit |

## Verification
The interesting collision is a capture edge reaching the output register in the very cycle that enable drops. The bench provokes it by raising the external clock and then clearing enable exactly two falling system-clock edges later, which should drop the bit. It then repeats this one cycle later, where the bit must still come out. The outcome is judged against the queue of expected bits, so a missing strobe or an extra one both show. A second pairing is a Manchester transition arriving right after re-enable: flushing and first-edge acceptance meet there, and an unflushed decoder would discard that transition.

// File: rtl/sdrx_pkg.sv
`timescale 1ns/1ps
// Shared codes for the delta-sigma input channel.
// Assumes: the interface and source codes are 2-bit fields driven by configuration.
package sdrx_pkg;
    typedef enum logic [1:0] {
        IF_SPI_RISE  = 2'd0,
        IF_SPI_FALL  = 2'd1,
        IF_MAN_RISE0 = 2'd2,
        IF_MAN_RISE1 = 2'd3
    } sdrx_if_e;

    typedef enum logic [1:0] {
        SRC_EXT       = 2'd0,
        SRC_INT       = 2'd1,
        SRC_HALF_FALL = 2'd2,
        SRC_HALF_RISE = 2'd3
    } sdrx_src_e;

    localparam int PIN_DATA = 0;
    localparam int PIN_ALT  = 1;
    localparam int PIN_CEXT = 2;
    localparam int PIN_CINT = 3;
    localparam int NUM_PINS = 4;
endpackage

// File: rtl/sdrx_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer with an extra history stage per pin, giving the level
// and single-cycle rise and fall pulses in the clk domain.
// Assumes: pins are held low during reset, so no spurious edge follows reset.
module sdrx_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic meta_q, sync_q, hist_q;

        // Cross the pin into clk and keep one cycle of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                hist_q <= 1'b0;
            end else begin
                meta_q <= pin[i];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        assign lvl[i]  = sync_q;
        assign rise[i] = sync_q & ~hist_q;
        assign fall[i] = ~sync_q & hist_q;
    end
endmodule

// File: rtl/sdrx_clk_sel.sv
`timescale 1ns/1ps
// Bit clock selection for the clocked interface codes: chooses the external
// or internal clock, or an internal clock halved on one chosen edge, and
// returns a capture pulse on the requested edge of the chosen clock.
// Assumes: edge pulses are already synchronized; the halved phase restarts low
// whenever the channel is disabled.
module sdrx_clk_sel
    import sdrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  sdrx_src_e src,
    input  logic      fall_sel,
    input  logic      ext_rise,
    input  logic      ext_fall,
    input  logic      int_rise,
    input  logic      int_fall,
    output logic      cap
);
    logic half_q;
    logic half_tick;

    // Pick which internal edge advances the halved clock.
    always_comb begin
        case (src)
            SRC_HALF_FALL: half_tick = int_fall;
            SRC_HALF_RISE: half_tick = int_rise;
            default:       half_tick = 1'b0;
        endcase
    end

    // Halved clock phase, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            half_q <= 1'b0;
        end else if (half_tick) begin
            half_q <= ~half_q;
        end
    end

    // Capture on the requested edge of the selected clock.
    always_comb begin
        case (src)
            SRC_EXT: cap = fall_sel ? ext_fall : ext_rise;
            SRC_INT: cap = fall_sel ? int_fall : int_rise;
            default: cap = half_tick & (fall_sel ? half_q : ~half_q);
        endcase
    end
endmodule

// File: rtl/sdrx_manch.sv
`timescale 1ns/1ps
// Manchester decoder: takes the first transition after enable as mid-bit,
// then accepts a transition only when at least 3/4 of a bit period of system
// clocks has passed since the last accepted one. The polarity input picks
// whether a rising transition means 1.
// Assumes: bit_cycles is at least 4 and stable while enabled.
module sdrx_manch #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rise_is_one,
    input  logic [CNT_W-1:0] bit_cycles,
    input  logic             d_rise,
    input  logic             d_fall,
    output logic             mid,
    output logic             mid_bit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             locked_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] accept_thr;

    assign accept_thr = (bit_cycles >> 1) + (bit_cycles >> 2);

    // Decide whether the present transition is a mid-bit one.
    always_comb begin
        mid     = en & (d_rise | d_fall) & (~locked_q | (cnt_q >= accept_thr));
        mid_bit = rise_is_one ? d_rise : d_fall;
    end

    // Lock flag and elapsed-cycle counter, flushed while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            locked_q <= 1'b0;
            cnt_q    <= '0;
        end else if (mid) begin
            locked_q <= 1'b1;
            cnt_q    <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sd_rx_channel.sv
`timescale 1ns/1ps
// One delta-sigma input channel: synchronizes the pins, selects the data pin,
// then either captures on a chosen clock edge or decodes Manchester code, and
// registers a one-bit sample with a single-cycle strobe.
// Assumes: configuration changes only while cfg_enable is low; bit clocks are
// slower than a quarter of clk.
module sd_rx_channel
    import sdrx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_type,
    input  logic [1:0]       cfg_clk_src,
    input  logic             cfg_alt_sel,
    input  logic [CNT_W-1:0] cfg_bit_cycles,
    input  logic             sd_data,
    input  logic             sd_data_alt,
    input  logic             sd_clk_ext,
    input  logic             sd_clk_int,
    output logic             smp_bit,
    output logic             smp_valid
);
    logic [NUM_PINS-1:0] pins, lvl, rise, fall;
    logic                d_lvl, d_rise, d_fall;
    logic                spi_cap, man_mid, man_bit;
    logic                is_man, evt, evt_bit;
    sdrx_if_e            if_code;
    sdrx_src_e           src_code;

    assign if_code  = sdrx_if_e'(cfg_type);
    assign src_code = sdrx_src_e'(cfg_clk_src);

    // Gather the asynchronous pins for the synchronizer.
    always_comb begin
        pins           = '0;
        pins[PIN_DATA] = sd_data;
        pins[PIN_ALT]  = sd_data_alt;
        pins[PIN_CEXT] = sd_clk_ext;
        pins[PIN_CINT] = sd_clk_int;
    end

    sdrx_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pins),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    // Choose the own or the neighbouring data pin.
    always_comb begin
        d_lvl  = cfg_alt_sel ? lvl[PIN_ALT]  : lvl[PIN_DATA];
        d_rise = cfg_alt_sel ? rise[PIN_ALT] : rise[PIN_DATA];
        d_fall = cfg_alt_sel ? fall[PIN_ALT] : fall[PIN_DATA];
    end

    sdrx_clk_sel u_clk_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_enable),
        .src     (src_code),
        .fall_sel(if_code == IF_SPI_FALL),
        .ext_rise(rise[PIN_CEXT]),
        .ext_fall(fall[PIN_CEXT]),
        .int_rise(rise[PIN_CINT]),
        .int_fall(fall[PIN_CINT]),
        .cap     (spi_cap)
    );

    sdrx_manch #(.CNT_W(CNT_W)) u_manch (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_enable),
        .rise_is_one(if_code == IF_MAN_RISE1),
        .bit_cycles (cfg_bit_cycles),
        .d_rise     (d_rise),
        .d_fall     (d_fall),
        .mid        (man_mid),
        .mid_bit    (man_bit)
    );

    // Merge the two decoding paths into one event.
    always_comb begin
        is_man  = (if_code == IF_MAN_RISE0) || (if_code == IF_MAN_RISE1);
        evt     = cfg_enable & (is_man ? man_mid : spi_cap);
        evt_bit = is_man ? man_bit : d_lvl;
    end

    // Output sample register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_bit   <= 1'b0;
        end else begin
            smp_valid <= evt;
            if (evt) begin
                smp_bit <= evt_bit;
            end
        end
    end
endmodule

// File: rtl/sdrx_chk.sv
`timescale 1ns/1ps
// Port-level checker for the input channel, bound to every instance.
// Assumes: a selected bit clock holds each level for at least four clk cycles.
module sdrx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_enable,
    input logic [1:0] cfg_type,
    input logic [1:0] cfg_clk_src,
    input logic       cfg_alt_sel,
    input logic       sd_data,
    input logic       sd_data_alt,
    input logic       sd_clk_ext,
    input logic       smp_bit,
    input logic       smp_valid
);
    logic din;
    assign din = cfg_alt_sel ? sd_data_alt : sd_data;

    // R2
    ext_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_type == 2'd0 && cfg_clk_src == 2'd0)
        |-> ($past(sd_clk_ext, 3) && !$past(sd_clk_ext, 4)));

    // R3
    ext_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_type == 2'd1 && cfg_clk_src == 2'd0)
        |-> (!$past(sd_clk_ext, 3) && $past(sd_clk_ext, 4)));

    // R7
    captured_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cfg_type[1] && cfg_clk_src == 2'd0)
        |-> (smp_bit == $past(din, 3)));

    // R4
    manch_transition_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_type[1]) |-> ($past(din, 3) != $past(din, 4)));

    // R5
    manch_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_type[1])
        |-> (smp_bit == (cfg_type[0] ? $past(din, 3) : !$past(din, 3))));

    // R8
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(cfg_enable));
endmodule

bind sd_rx_channel sdrx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_type   (cfg_type),
    .cfg_clk_src(cfg_clk_src),
    .cfg_alt_sel(cfg_alt_sel),
    .sd_data    (sd_data),
    .sd_data_alt(sd_data_alt),
    .sd_clk_ext (sd_clk_ext),
    .smp_bit    (smp_bit),
    .smp_valid  (smp_valid)
);

// File: tb/sim_sd_rx_channel.sv
`timescale 1ns/1ps
// Bench: a behavioural model queues the bits each stimulus should yield, and
// every clock the strobe output is matched against the queue head.
module sim_sd_rx_channel;
    localparam int CW   = 8;
    localparam int BITC = 16;
    localparam int HALF = BITC / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_enable;
    logic [1:0]    cfg_type, cfg_clk_src;
    logic          cfg_alt_sel;
    logic [CW-1:0] cfg_bit_cycles;
    logic          sd_data, sd_data_alt, sd_clk_ext, sd_clk_int;
    logic          smp_bit, smp_valid;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    exp_q[$];
    string cur_req = "R1";
    bit    line_lvl = 1'b0;

    always #2.5 clk = ~clk;

    sd_rx_channel #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_type(cfg_type),
        .cfg_clk_src(cfg_clk_src), .cfg_alt_sel(cfg_alt_sel),
        .cfg_bit_cycles(cfg_bit_cycles), .sd_data(sd_data),
        .sd_data_alt(sd_data_alt), .sd_clk_ext(sd_clk_ext),
        .sd_clk_int(sd_clk_int), .smp_bit(smp_bit), .smp_valid(smp_valid)
    );

    // Per-clock comparison of strobes against the expected queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done && smp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: strobe with bit %0b, expected no strobe", cur_req, smp_bit);
            end else begin
                bit e;
                e = exp_q.pop_front();
                if (smp_bit !== e) begin
                    errors++;
                    $display("FAIL %s: bit %0b, expected %0b", cur_req, smp_bit, e);
                end
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_data(bit v);
        if (cfg_alt_sel) begin
            sd_data_alt = v;
            sd_data     = ~v;
        end else begin
            sd_data     = v;
            sd_data_alt = ~v;
        end
        line_lvl = v;
    endtask

    task automatic expect_empty(string req);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d bits missing, expected 0", req, exp_q.size());
        end
        exp_q.delete();
    endtask

    task automatic setup(bit [1:0] typ, bit [1:0] src, bit alt);
        cfg_enable = 1'b0;
        cyc(2);
        cfg_type    = typ;
        cfg_clk_src = src;
        cfg_alt_sel = alt;
        sd_clk_ext  = 1'b0;
        sd_clk_int  = 1'b0;
        put_data(1'b0);
        cyc(5);
    endtask

    // One clocked slot: data, then main clock up at t2 and down at t6, the
    // other clock toggling on odd cycles as noise.
    task automatic slot(bit b, bit main_is_ext);
        for (int t = 0; t < 8; t++) begin
            if (t == 0) put_data(b);
            if (t == 2 || t == 6) begin
                if (main_is_ext) sd_clk_ext = ~sd_clk_ext;
                else             sd_clk_int = ~sd_clk_int;
            end
            if (t % 2 == 1) begin
                if (main_is_ext) sd_clk_int = ~sd_clk_int;
                else             sd_clk_ext = ~sd_clk_ext;
            end
            cyc(1);
        end
    endtask

    // Clocked-mode phase; the model decides which slots are captured.
    task automatic spi_phase(string req, bit [1:0] typ, bit [1:0] src, bit alt,
                             bit en, bit [15:0] pat);
        cur_req = req;
        setup(typ, src, alt);
        cfg_enable = en;
        cyc(4);
        for (int k = 1; k <= 16; k++) begin
            bit take;
            if (src < 2) take = 1'b1;
            else         take = (typ == 2'd0) ? (k % 2 == 1) : (k % 2 == 0);
            if (take && en) exp_q.push_back(pat[k-1]);
            slot(pat[k-1], src == 2'd0);
        end
        cyc(6);
        expect_empty(req);
        cfg_enable = 1'b0;
    endtask

    function automatic bit first_half(bit b, bit [1:0] typ);
        return (typ == 2'd2) ? b : ~b;
    endfunction

    // Manchester stream led by a bit whose first half matches the line.
    task automatic man_stream(bit [1:0] typ, int n, bit [15:0] pat);
        bit lead;
        lead = (typ == 2'd2) ? line_lvl : ~line_lvl;
        for (int i = -1; i < n; i++) begin
            bit b;
            b = (i < 0) ? lead : pat[i];
            put_data(first_half(b, typ));
            cyc(HALF);
            exp_q.push_back(b);
            put_data(~first_half(b, typ));
            cyc(HALF);
        end
    endtask

    task automatic man_phase(string req, bit [1:0] typ, bit alt, int n, bit [15:0] pat);
        cur_req = req;
        setup(typ, 2'd0, alt);
        cfg_enable = 1'b1;
        cyc(4);
        man_stream(typ, n, pat);
        cyc(6);
        expect_empty(req);
        cfg_enable = 1'b0;
    endtask

    // Capture edge meeting the enable drop; gap picks the negedge of the drop.
    task automatic collide(int gap, bit keep);
        cur_req = "R8";
        setup(2'd0, 2'd0, 1'b0);
        cfg_enable = 1'b1;
        put_data(1'b1);
        cyc(4);
        sd_clk_ext = 1'b1;
        if (keep) exp_q.push_back(1'b1);
        cyc(gap);
        cfg_enable = 1'b0;
        cyc(6);
        sd_clk_ext = 1'b0;
        cyc(4);
        expect_empty("R8");
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_enable = 1'b0; cfg_type = 2'd0; cfg_clk_src = 2'd0; cfg_alt_sel = 1'b0;
        cfg_bit_cycles = CW'(BITC);
        sd_data = 1'b0; sd_data_alt = 1'b0; sd_clk_ext = 1'b0; sd_clk_int = 1'b0;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        checks++;  // R1 reset state
        if (smp_valid !== 1'b0 || smp_bit !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid %0b bit %0b, expected 0 0", smp_valid, smp_bit);
        end

        spi_phase("R2", 2'd0, 2'd0, 1'b0, 1'b1, 16'hB52D);
        spi_phase("R3", 2'd1, 2'd0, 1'b0, 1'b1, 16'h6C93);
        spi_phase("R6", 2'd0, 2'd1, 1'b0, 1'b1, 16'hA5F0);
        spi_phase("R6", 2'd1, 2'd1, 1'b0, 1'b1, 16'h0F5A);
        spi_phase("R6", 2'd0, 2'd2, 1'b0, 1'b1, 16'hC3A9);
        spi_phase("R6", 2'd1, 2'd2, 1'b0, 1'b1, 16'h3C56);
        spi_phase("R6", 2'd0, 2'd3, 1'b0, 1'b1, 16'h9B1E);
        spi_phase("R6", 2'd1, 2'd3, 1'b0, 1'b1, 16'h64E1);
        spi_phase("R7", 2'd0, 2'd0, 1'b1, 1'b1, 16'h1DE4);
        spi_phase("R7", 2'd1, 2'd1, 1'b1, 1'b1, 16'hE21B);
        spi_phase("R8", 2'd0, 2'd0, 1'b0, 1'b0, 16'hFFFF);
        collide(2, 1'b0);
        collide(3, 1'b1);

        man_phase("R4", 2'd2, 1'b0, 10, 16'h0263);
        man_phase("R5", 2'd3, 1'b0, 10, 16'h0263);
        man_phase("R7", 2'd2, 1'b1, 8, 16'h00B4);
        man_phase("R10", 2'd3, 1'b0, 12, 16'h0F0F);

        // R9: flush by a short disable, then a transition soon after re-enable
        cur_req = "R9";
        setup(2'd2, 2'd0, 1'b0);
        cfg_enable = 1'b1;
        cyc(4);
        man_stream(2'd2, 3, 16'h0005);
        cfg_enable = 1'b0;
        cyc(3);
        cfg_enable = 1'b1;
        cyc(1);
        man_stream(2'd2, 4, 16'h0009);
        cyc(6);
        expect_empty("R9");
        cfg_enable = 1'b0;
        cyc(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run not finished, expected end of stimulus");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule